// File: doc/BRIEF.md
# Parallel SAR Converter Conversion Sequencer

This block is a clock-accurate digital model of the control and readout logic of a 16-bit, four-channel successive-approximation converter with a parallel bus. It divides a fast input clock down to an internal conversion clock. It detects a conversion start from an active-low chip select and an active-low convert strobe, and runs a conversion of fixed length with a busy flag. It then holds the result in an output register and presents that register on a data bus with an output enable. The bus can also run in byte-wide mode. Each channel's analog value arrives as a 16-bit two's-complement word on `chan_in`. Pulse widths are counted in fast-clock cycles.

The controller has four states. ST_READY waits for a start and has the acquisition complete. ST_ARMED has a start captured and waits for the next internal clock edge. ST_CONVERT has busy high for the conversion clocks. ST_ACQUIRE is the mandatory acquisition gap. The transitions are: READY to ARMED on an accepted start; ARMED to CONVERT on an internal tick; CONVERT to ACQUIRE on the last conversion tick; ACQUIRE to READY on the last acquisition tick. The channel address is pipelined by one conversion. The address given with one start selects the channel that is tracked after that conversion ends, and therefore the channel sampled by the next start.

Top module: `sar_seq`

## Requirements
- R1: The internal clock is the fast clock divided by 1, 2, 4 or 8 for `div_sel` = 0, 1, 2, 3. A conversion lasts 17 internal clocks, so `busy` stays high for exactly 17*N fast cycles, where N is the divide ratio.
- R2: A start is the fast cycle in which (`cs_n` low AND `conv_n` low) becomes true after being false. After reset the condition counts as already true, so a new falling transition is needed. The conversion begins on the first internal clock edge after that cycle: `busy` is seen high between 2 and N+1 fast edges after the start is applied.
- R3: When `busy` falls, the output register loads the word sampled at the beginning of that conversion. The register does not change while `busy` stays high.
- R4: After `busy` falls, 3 internal clocks of acquisition follow. A start that occurs during them is ignored and does not produce a conversion.
- R5: A start that occurs while `busy` is high is ignored. The current conversion keeps its length, and no extra conversion follows.
- R6: After an accepted start, the first rising edge of `cs_n` or `conv_n` latches `addr`. That channel is the one sampled by the following start. The first conversion after reset samples channel 0.
- R7: `bus_en` is high only when `cs_n` and `rd_n` are both low, `busy` is low and reset is inactive. It drops in the same cycle that `busy` rises, even if `rd_n` stays low. `bus_o` is 0 whenever `bus_en` is low.
- R8: When `byte_sel` is 0, result bits 15..0 appear on `bus_o[15:0]`. When `byte_sel` is 1, result bits 15..8 appear on `bus_o[7:0]` and `bus_o[15:8]` is 0. `byte_sel` acts combinationally, with no clock edge needed.
- R9: Reset (active-low, asynchronous) clears the output register, drives `busy` low, disables the bus and sets the tracked channel to 0.
- R10: The result is the channel word in two's-complement form, passed through unchanged (for example 0x8000 and 0x7FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Internal clock divide select (ratio 2^div_sel) |
| cs_n | input | 1 | Active-low chip select |
| conv_n | input | 1 | Active-low convert strobe |
| rd_n | input | 1 | Active-low read strobe |
| byte_sel | input | 1 | 1 = upper byte on low lines |
| addr | input | 2 | Channel address for the next conversion |
| chan_in | input | 64 | Four 16-bit channel words, channel 0 in bits 15..0 |
| busy | output | 1 | High while a conversion runs |
| bus_o | output | 16 | Data bus value |
| bus_en | output | 1 | Data bus output enable; low means high impedance |

## Verification
The bench builds the block with its default parameters: 16-bit words, four channels, a two-bit divide select, 17 conversion clocks and 3 acquisition clocks. The two-bit select brings every divide ratio into reach, and the bench steps through all four. With ratio 1 the start-to-busy latency is exact. With ratio 8 the 24-cycle acquisition window is wide enough to inject an ignored start inside it. The four channel words include both two's-complement extremes and a value whose upper and lower bytes differ, so lane swaps in byte mode are visible.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CONVERT = 2'd2,
        ST_ACQUIRE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sar_seq_clkdiv.sv
// Free-running divider: one tick every 2^div_sel fast cycles (R1)
module sar_seq_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W:0]   span;

    always_comb begin
        span = {{CNT_W{1'b0}}, 1'b1} << div_sel;
        mask = CNT_W'(span - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q & mask) == mask;

endmodule

// File: rtl/sar_seq_edges.sv
// Start detection (R2) and address-latch edge detection (R6)
module sar_seq_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic conv_n,
    output logic start_pulse,
    output logic rise_pulse
);
    logic cond_prev_q;
    logic cs_prev_q;
    logic conv_prev_q;
    logic start_cond;

    assign start_cond  = !cs_n && !conv_n;
    assign start_pulse = start_cond && !cond_prev_q;
    assign rise_pulse  = (cs_n && !cs_prev_q) || (conv_n && !conv_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_prev_q <= 1'b1;
            cs_prev_q   <= 1'b1;
            conv_prev_q <= 1'b1;
        end else begin
            cond_prev_q <= start_cond;
            cs_prev_q   <= cs_n;
            conv_prev_q <= conv_n;
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
// Conversion sequencer state machine (R1, R2, R4, R5)
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CONV_TICKS = 17,
    parameter int ACQ_TICKS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_pulse,
    output logic busy,
    output logic accept,
    output logic sample_en,
    output logic finish
);
    localparam int MAX_T = (CONV_TICKS > ACQ_TICKS) ? CONV_TICKS : ACQ_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_TICKS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (start_pulse)                 state_d = ST_ARMED;
            ST_ARMED:   if (tick)                        state_d = ST_CONVERT;
            ST_CONVERT: if (tick && cnt_q == CONV_LAST)  state_d = ST_ACQUIRE;
            ST_ACQUIRE: if (tick && cnt_q == ACQ_LAST)   state_d = ST_READY;
            default:                                     state_d = ST_READY;
        endcase
    end

    // state register and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (tick)          cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= (state_d == ST_CONVERT);
    end

    always_comb begin
        accept    = (state_q == ST_READY)   && start_pulse;
        sample_en = (state_q == ST_ARMED)   && tick;
        finish    = (state_q == ST_CONVERT) && tick && (cnt_q == CONV_LAST);
    end

endmodule

// File: rtl/sar_seq_datapath.sv
// Channel pipeline, sample/result registers and bus drive (R3, R6..R10)
module sar_seq_datapath #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CH_W-1:0]          addr,
    input  logic [NUM_CH*DATA_W-1:0] chan_in,
    input  logic                     accept,
    input  logic                     rise_pulse,
    input  logic                     sample_en,
    input  logic                     finish,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     byte_sel,
    input  logic                     busy,
    output logic [DATA_W-1:0]        result,
    output logic [DATA_W-1:0]        bus_o,
    output logic                     bus_en
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] chan_arr [NUM_CH];
    logic              addr_wait_q;
    logic [CH_W-1:0]   next_ch_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic [DATA_W-1:0] sample_q;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] word;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign chan_arr[g] = chan_in[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_wait_q <= 1'b0;
            next_ch_q   <= '0;
            cur_ch_q    <= '0;
            sample_q    <= '0;
            result_q    <= '0;
        end else begin
            if (accept) begin
                addr_wait_q <= 1'b1;
            end else if (rise_pulse && addr_wait_q) begin
                addr_wait_q <= 1'b0;
                next_ch_q   <= addr;
            end
            if (sample_en) sample_q <= chan_arr[cur_ch_q];
            if (finish) begin
                result_q <= sample_q;
                cur_ch_q <= next_ch_q;
            end
        end
    end

    always_comb begin
        word   = byte_sel ? {{(DATA_W-HALF){1'b0}}, result_q[DATA_W-1:HALF]} : result_q;
        bus_en = rst_n && !cs_n && !rd_n && !busy;
        bus_o  = bus_en ? word : '0;
    end

    assign result = result_q;

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int DATA_W     = 16,
    parameter int NUM_CH     = 4,
    parameter int SEL_W      = 2,
    parameter int CONV_TICKS = 17,
    parameter int ACQ_TICKS  = 3,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         div_sel,
    input  logic                     cs_n,
    input  logic                     conv_n,
    input  logic                     rd_n,
    input  logic                     byte_sel,
    input  logic [CH_W-1:0]          addr,
    input  logic [NUM_CH*DATA_W-1:0] chan_in,
    output logic                     busy,
    output logic [DATA_W-1:0]        bus_o,
    output logic                     bus_en
);
    logic              tick;
    logic              start_pulse;
    logic              rise_pulse;
    logic              accept;
    logic              sample_en;
    logic              finish;
    logic [DATA_W-1:0] result_w;

    sar_seq_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick)
    );

    sar_seq_edges u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .conv_n      (conv_n),
        .start_pulse (start_pulse),
        .rise_pulse  (rise_pulse)
    );

    sar_seq_fsm #(.CONV_TICKS(CONV_TICKS), .ACQ_TICKS(ACQ_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_pulse (start_pulse),
        .busy        (busy),
        .accept      (accept),
        .sample_en   (sample_en),
        .finish      (finish)
    );

    sar_seq_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .chan_in    (chan_in),
        .accept     (accept),
        .rise_pulse (rise_pulse),
        .sample_en  (sample_en),
        .finish     (finish),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .byte_sel   (byte_sel),
        .busy       (busy),
        .result     (result_w),
        .bus_o      (bus_o),
        .bus_en     (bus_en)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int DATA_W     = 16,
    parameter int SEL_W      = 2,
    parameter int CONV_TICKS = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              byte_sel,
    input logic              busy,
    input logic              bus_en,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] result
);
    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int HALF    = DATA_W / 2;

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    assert_float_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !bus_en);

    assert_float_when_rd_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !bus_en);

    assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy ##1 busy |-> $stable(result));

    assert_busy_upper_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CONV_TICKS * MAX_DIV);

    assert_busy_lower_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q >= CONV_TICKS);

    assert_byte_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && byte_sel) |-> bus_o[DATA_W-1:HALF] == '0);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R9: assert (!busy && !bus_en && result == '0);
        end
    end

endmodule

bind sar_seq sar_seq_chk #(
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .CONV_TICKS (CONV_TICKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .busy     (busy),
    .bus_en   (bus_en),
    .bus_o    (bus_o),
    .result   (result_w)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  div_sel;
    logic        cs_n, conv_n, rd_n, byte_sel;
    logic [1:0]  addr;
    logic [63:0] chan_in;
    logic        busy;
    logic [15:0] bus_o;
    logic        bus_en;

    logic [15:0] vals [4] = '{16'h1234, 16'h8000, 16'h7FFF, 16'hFEDC};

    int          n_chk = 0;
    int          n_fail = 0;
    int          run_len = 0;
    int          last_len = 0;
    int          model_cur = 0;
    bit          sb_on = 0;
    bit          done = 0;
    logic        prev_busy = 1'b0;
    logic [15:0] exp_q [$];
    logic [15:0] e_word;
    logic [15:0] last_word = 16'h0;

    always #5 clk = ~clk;

    assign chan_in = {vals[3], vals[2], vals[1], vals[0]};

    sar_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .cs_n     (cs_n),
        .conv_n   (conv_n),
        .rd_n     (rd_n),
        .byte_sel (byte_sel),
        .addr     (addr),
        .chan_in  (chan_in),
        .busy     (busy),
        .bus_o    (bus_o),
        .bus_en   (bus_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: busy width tracking and scoreboard compare at each busy fall
    always @(negedge clk) begin
        if (busy === 1'b1) run_len++;
        else begin
            if (run_len != 0) last_len = run_len;
            run_len = 0;
        end
        if (sb_on && prev_busy === 1'b1 && busy === 1'b0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected result", {16'h0, bus_o}, 32'h0);
            end else begin
                e_word = exp_q.pop_front();
                check(bus_en === 1'b1 && bus_o === e_word, "R3/R6/R10 result word",
                      {15'h0, bus_en, bus_o}, {16'h1, e_word});
                last_word = e_word;
            end
        end
        prev_busy = busy;
    end

    // driver: mode 0 plain, 1 extra start while busy (R5), 2 start during acquisition (R4)
    task automatic convert(input logic [1:0] a, input int n, input int mode);
        int lat;
        bit seen;
        lat  = 0;
        seen = 0;
        @(negedge clk);
        addr   = a;
        conv_n = 1'b0;
        exp_q.push_back(vals[model_cur]);
        model_cur = a;
        do begin
            @(negedge clk); #1;
            lat++;
            if (lat == 1) conv_n = 1'b1;
        end while (busy !== 1'b1 && lat < 40);
        check(lat >= 2 && lat <= n + 1, "R2 start latency", lat, n + 1);
        check(bus_en === 1'b0, "R7 bus floats on busy rise", {31'h0, bus_en}, 32'h0);
        if (mode == 1) begin
            repeat (4) @(negedge clk);
            addr   = 2'd3;
            conv_n = 1'b0;
            @(negedge clk);
            conv_n = 1'b1;
            @(negedge clk);
            addr   = a;
        end
        do begin
            @(negedge clk); #1;
        end while (busy === 1'b1);
        check(last_len == 17 * n, "R1 busy width", last_len, 17 * n);
        if (mode == 2) begin
            conv_n = 1'b0;
            @(negedge clk); #1;
            conv_n = 1'b1;
        end
        repeat (3 * n + 3) begin
            @(negedge clk); #1;
            if (busy === 1'b1) seen = 1;
        end
        if (mode == 1) check(!seen, "R5 no extra conversion", {31'h0, seen}, 32'h0);
        if (mode == 2) check(!seen, "R4 start in acquisition ignored", {31'h0, seen}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R3 watchdog expired", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; div_sel = 2'd0; cs_n = 1'b0; conv_n = 1'b1;
        rd_n = 1'b0; byte_sel = 1'b0; addr = 2'd0;
        repeat (3) @(negedge clk);
        #1;
        check(busy === 1'b0, "R9 busy low in reset", {31'h0, busy}, 32'h0);
        check(bus_en === 1'b0, "R9 bus floats in reset", {31'h0, bus_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(bus_en === 1'b1 && bus_o === 16'h0, "R9 result cleared", {16'h0, bus_o}, 32'h0);
        sb_on = 1;

        convert(2'd1, 1, 0);              // R6: channel 0 after reset
        convert(2'd2, 1, 0);              // R10: 0x8000
        convert(2'd3, 1, 0);              // R10: 0x7FFF
        div_sel = 2'd1; convert(2'd0, 2, 0);
        div_sel = 2'd2; convert(2'd2, 4, 0);
        div_sel = 2'd3; convert(2'd1, 8, 1);   // R5
        convert(2'd3, 8, 2);                   // R4, also R6: addr 3 from ignored start not used
        convert(2'd0, 8, 0);                   // expects channel 3
        repeat (4) @(negedge clk);
        sb_on = 0;
        check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 32'h0);

        rd_n = 1'b1; #1;
        check(bus_en === 1'b0, "R7 read high floats", {31'h0, bus_en}, 32'h0);
        rd_n = 1'b0; #1;
        check(bus_en === 1'b1 && bus_o === last_word, "R7 read word", {16'h0, bus_o}, {16'h0, last_word});
        byte_sel = 1'b1; #1;
        check(bus_o === {8'h00, last_word[15:8]}, "R8 upper byte on low lines",
              {16'h0, bus_o}, {24'h0, last_word[15:8]});
        byte_sel = 1'b0; #1;
        check(bus_o === last_word, "R8 full word", {16'h0, bus_o}, {16'h0, last_word});
        cs_n = 1'b1; #1;
        check(bus_en === 1'b0 && bus_o === 16'h0, "R7 chip select high floats",
              {15'h0, bus_en, bus_o}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule